// File: doc/BRIEF.md
# Configurable GPIO Port Controller

An eight-pin general-purpose I/O port driven from a small register bus. Three registers sit on the bus: a global control register, a port data latch and a per-pin drive-mode register. The block turns them into three control vectors for tri-state pads: an output enable, an output value and a weak-pullup enable for each pin.

Each pin is either open-drain or push-pull, as its mode bit selects. An open-drain pin pulls low for a latch value of 0 and lets go of the line for a latch value of 1. A push-pull pin drives both levels. Pin levels come back through a two-flop synchronizer. A global input-enable bit decides whether a read of the port returns those levels or zero. Weak pullups switch on only for open-drain pins that are let go high. One control bit replaces pin 0's latch with an inverted copy of the system clock.

Writes land on the rising clock edge after the strobe. Reads are combinational from the current address.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the control register reads 0x40, the drive-mode register reads 0x00 and the data latch holds 0xFF. All pins are then released (output enable 0) with pullups on.
- R2: Control bits 5 to 1 always read as 0 and ignore writes. Bit 7 (pullup disable), bit 6 (input enable) and bit 0 (clock on pin 0) are read/write.
- R3: A write with the strobe high takes effect at the next rising edge. Control is at address 0xE2, the data latch at 0x80 and drive mode at 0xA4. The drive-mode register reads back what was written.
- R4: Any other address reads as 0x00, and a write to it changes no register or pin output.
- R5: A pin whose mode bit is 1 (push-pull) has output enable 1 and an output value equal to its latch bit.
- R6: A pin whose mode bit is 0 (open-drain) has output enable 1 and output value 0 when its latch bit is 0, and output enable 0 when its latch bit is 1.
- R7: While input enable (control bit 6) is 0, a read of address 0x80 returns 0x00.
- R8: While input enable is 1, a read of address 0x80 returns the pin input levels sampled two rising edges earlier, not the latch.
- R9: A pin's pullup is on exactly when control bit 7 is 0, its latch bit is 1, its mode bit is 0 and it is not carrying the clock.
- R10: While control bit 0 is 1, pin 0 outputs the inverse of the clock input with output enable 1 and pullup 0, whatever its latch or mode bit says. While bit 0 is 0, pin 0 follows its latch.
- R11: The reset is synchronous and active-low. When it is asserted during operation, all three registers return to their R1 values at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the source of the inverted clock on pin 0 |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, acted on at the rising edge |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 8 | Pin levels from the pads, asynchronous |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin weak-pullup enable |

## Verification
The assertions assume that rst_n is low from time zero and held through at least the first edge. They also assume that bus_addr, bus_we, bus_wdata and pin_in carry known values at every rising edge, so the synchronizer-lag and write-landing properties compare defined data. The bench drives every input only on the falling edge, starts in reset, and never leaves an input undriven. Pin levels are stepped independently of the latch, so a read that returned the latch instead of the pins would show up.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the GPIO port controller.
// Assumes an 8-bit register bus; addresses and reset values live here.
package gpio_port_pkg;
    localparam int unsigned BUS_W = 8;
    localparam logic [BUS_W-1:0] ADR_CTRL = 8'hE2;
    localparam logic [BUS_W-1:0] ADR_DATA = 8'h80;
    localparam logic [BUS_W-1:0] ADR_MODE = 8'hA4;
    localparam logic [BUS_W-1:0] CTRL_RST = 8'h40;
    localparam logic [BUS_W-1:0] DATA_RST = 8'hFF;
    localparam logic [BUS_W-1:0] MODE_RST = 8'h00;
    localparam int unsigned CB_PU_OFF  = 7;
    localparam int unsigned CB_IN_EN   = 6;
    localparam int unsigned CB_CLK_SEL = 0;

    // Implemented control bits only; unused bits are not stored.
    typedef struct packed {
        logic pu_off;
        logic in_en;
        logic clk_sel;
    } ctrl_t;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Module: gpio_in_sync
// Brings asynchronous pin levels into the clock domain through a chain of
// STAGES flops per pin. Assumes STAGES >= 1; the chain clears on reset.
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift pin levels one stage per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign pin_sync = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lag_chk
            // R8: synchronized value lags the pins by two edges
            p_sync_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n, 2) && $past(rst_n)) |-> (pin_sync == $past(pin_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
// Module: gpio_regs
// Holds the control, data-latch and drive-mode registers, decodes bus
// writes and builds the combinational read data. Assumes pin_sync is
// already in the clock domain.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] pin_sync,
    output ctrl_t            ctrl_o,
    output logic [WIDTH-1:0] latch_o,
    output logic [WIDTH-1:0] mode_o,
    output logic [BUS_W-1:0] bus_rdata
);
    localparam int unsigned FILL_W = BUS_W - WIDTH;

    ctrl_t            ctrl_q;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] mode_q;
    logic [WIDTH-1:0] port_view;

    // Register writes and synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.pu_off  <= CTRL_RST[CB_PU_OFF];
            ctrl_q.in_en   <= CTRL_RST[CB_IN_EN];
            ctrl_q.clk_sel <= CTRL_RST[CB_CLK_SEL];
            latch_q        <= DATA_RST[WIDTH-1:0];
            mode_q         <= MODE_RST[WIDTH-1:0];
        end else if (bus_we) begin
            case (bus_addr)
                ADR_CTRL: begin
                    ctrl_q.pu_off  <= bus_wdata[CB_PU_OFF];
                    ctrl_q.in_en   <= bus_wdata[CB_IN_EN];
                    ctrl_q.clk_sel <= bus_wdata[CB_CLK_SEL];
                end
                ADR_DATA: latch_q <= bus_wdata[WIDTH-1:0];
                ADR_MODE: mode_q  <= bus_wdata[WIDTH-1:0];
                default: ;
            endcase
        end
    end

    // Input gating for port reads.
    assign port_view = ctrl_q.in_en ? pin_sync : '0;

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTRL: begin
                bus_rdata[CB_PU_OFF]  = ctrl_q.pu_off;
                bus_rdata[CB_IN_EN]   = ctrl_q.in_en;
                bus_rdata[CB_CLK_SEL] = ctrl_q.clk_sel;
            end
            ADR_DATA: bus_rdata = {{FILL_W{1'b0}}, port_view};
            ADR_MODE: bus_rdata = {{FILL_W{1'b0}}, mode_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign latch_o = latch_q;
    assign mode_o  = mode_q;

    // R3: a mode write is visible after the next edge
    p_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_MODE) |=> (mode_o == $past(bus_wdata[WIDTH-1:0])));
    // R2: unused control bits read zero
    p_ctrl_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_CTRL) |-> (bus_rdata[5:1] == 5'd0));
    // R7: gated port reads return zero
    p_read_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_DATA && !ctrl_o.in_en) |-> (bus_rdata == '0));
    // R1 and R11: registers hold reset values on leaving reset
    p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch_o == DATA_RST[WIDTH-1:0] && mode_o == MODE_RST[WIDTH-1:0]
                          && ctrl_o.in_en && !ctrl_o.pu_off && !ctrl_o.clk_sel));
endmodule

// File: rtl/gpio_pin_drive.sv
`timescale 1ns/1ps
// Module: gpio_pin_drive
// Turns latch, mode and control bits into per-pin output enable, value
// and weak-pullup enable. Pin 0 may carry the inverted clock, which
// forces push-pull drive. Assumes clk is the free-running system clock.
module gpio_pin_drive
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_i,
    input  logic [WIDTH-1:0] latch_i,
    input  logic [WIDTH-1:0] mode_i,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pu
);
    logic [WIDTH-1:0] clk_ovr;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            if (i == 0) begin : g_clk_pin
                // Pin 0: clock override selected by the control bit.
                assign clk_ovr[i] = ctrl_i.clk_sel;
            end else begin : g_plain_pin
                assign clk_ovr[i] = 1'b0;
            end
            // Drive value: inverted clock when overridden, else latch.
            assign pin_out[i] = clk_ovr[i] ? ~clk : latch_i[i];
            // Enable: override or push-pull always drive; open-drain drives only a 0.
            assign pin_oe[i]  = clk_ovr[i] | mode_i[i] | ~latch_i[i];
            // Pullup only on released open-drain pins.
            assign pin_pu[i]  = ~ctrl_i.pu_off & latch_i[i] & ~mode_i[i] & ~clk_ovr[i];

            // R9: a pin with its pullup on is never driven
            p_pu_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
                pin_pu[i] |-> !pin_oe[i]);
        end
    endgenerate

    // R10: pin 0 drives whenever the clock is routed to it
    p_clk_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i.clk_sel |-> (pin_oe[0] && !pin_pu[0]));
endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
// Module: gpio_port_ctrl (top)
// Eight-pin GPIO port with register bus, input synchronizer and pad
// drive logic. Assumes pads resolve pin_oe/pin_out/pin_pu externally.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_we,
    output logic [7:0]       bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pu
);
    ctrl_t            ctrl;
    logic [WIDTH-1:0] latch;
    logic [WIDTH-1:0] mode;
    logic [WIDTH-1:0] pin_sync;

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .pin_sync(pin_sync), .ctrl_o(ctrl), .latch_o(latch),
        .mode_o(mode), .bus_rdata(bus_rdata)
    );

    gpio_pin_drive #(.WIDTH(WIDTH)) u_drive (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .latch_i(latch), .mode_i(mode),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
    );

    // R4: a write to an unmapped address leaves the latch unchanged
    p_unmapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != ADR_DATA) |=> $stable(latch));
endmodule

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed checks.
module sim_gpio_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] pin_in = 8'h5A;
    logic [7:0] bus_rdata, pin_oe, pin_out, pin_pu;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Reference state
    logic [7:0] m_ctrl, m_latch, m_mode, m_s1, m_s2;

    always #2.5 clk = ~clk;

    gpio_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
    );

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl <= 8'h40; m_latch <= 8'hFF; m_mode <= 8'h00;
            m_s1 <= 8'h00; m_s2 <= 8'h00;
        end else begin
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (bus_we) begin
                if (bus_addr == 8'hE2) m_ctrl <= bus_wdata & 8'hC1;
                else if (bus_addr == 8'h80) m_latch <= bus_wdata;
                else if (bus_addr == 8'hA4) m_mode <= bus_wdata;
            end
        end
    end

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        if (a == 8'hE2) return m_ctrl;
        if (a == 8'h80) return m_ctrl[6] ? m_s2 : 8'h00;
        if (a == 8'hA4) return m_mode;
        return 8'h00;
    endfunction

    // Compare all outputs shortly after each rising edge (clk high)
    always begin
        @(posedge clk);
        #1;
        begin
            logic [7:0] e_oe, e_out, e_pu, ovr;
            string rtag;
            ovr   = {7'd0, m_ctrl[0]};
            e_oe  = ovr | m_mode | ~m_latch;
            e_out = (m_latch & ~ovr) | (ovr & {8{~clk}});
            e_pu  = {8{~m_ctrl[7]}} & m_latch & ~m_mode & ~ovr;
            if (bus_addr == 8'hE2) rtag = "R2";
            else if (bus_addr == 8'h80) rtag = m_ctrl[6] ? "R8" : "R7";
            else if (bus_addr == 8'hA4) rtag = "R3";
            else rtag = "R4";
            chk(rtag, "model rdata", bus_rdata, exp_rd(bus_addr));
            chk("R5 R6", "model pin_oe", pin_oe, e_oe);
            chk("R5 R6 R10", "model pin_out", pin_out, e_out);
            chk("R9", "model pin_pu", pin_pu, e_pu);
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    endtask

    task automatic rd(logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(posedge clk);
        #1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(8'hE2); chk("R1", "ctrl after reset", bus_rdata, 8'h40);
        rd(8'hA4); chk("R1", "mode after reset", bus_rdata, 8'h00);
        chk("R1", "oe after reset", pin_oe, 8'h00);
        chk("R1", "pu after reset", pin_pu, 8'hFF);

        // R2: unused control bits
        wr(8'hE2, 8'hFF);
        rd(8'hE2); chk("R2", "ctrl unused bits", bus_rdata, 8'hC1);
        wr(8'hE2, 8'h40);

        // R3 R5 R6 R9: mode and latch
        wr(8'hA4, 8'hA5);
        wr(8'h80, 8'h3C);
        rd(8'hA4); chk("R3", "mode readback", bus_rdata, 8'hA5);
        chk("R5 R6", "oe mixed modes", pin_oe, 8'hE7);
        chk("R5", "out mixed modes", pin_out, 8'h3C);
        chk("R9", "pullups mixed modes", pin_pu, 8'h18);

        // R8: two-edge lag, pins not latch
        @(negedge clk);
        bus_addr = 8'h80; bus_we = 1'b0; pin_in = 8'h96;
        @(posedge clk); #1;
        chk("R8", "port read after one edge", bus_rdata, 8'h5A);
        @(posedge clk); #1;
        chk("R8", "port read after two edges", bus_rdata, 8'h96);

        // R7: input gate
        wr(8'hE2, 8'h00);
        rd(8'h80); chk("R7", "gated port read", bus_rdata, 8'h00);

        // R4: unmapped addresses
        wr(8'h81, 8'h00);
        wr(8'hE3, 8'hFF);
        rd(8'h81); chk("R4", "unmapped read", bus_rdata, 8'h00);
        chk("R4", "latch after unmapped write", pin_out, 8'h3C);
        rd(8'hE2); chk("R4", "ctrl after unmapped write", bus_rdata, 8'h00);

        // R9: global pullup disable
        wr(8'hA4, 8'h00);
        wr(8'h80, 8'hFF);
        wr(8'hE2, 8'h80);
        rd(8'hE2); chk("R9", "pullups disabled", pin_pu, 8'h00);

        // R10: clock on pin 0
        wr(8'h80, 8'hFE);
        wr(8'hE2, 8'h41);
        rd(8'hE2);
        chk("R10", "pin0 high phase", {7'd0, pin_out[0]}, 8'h00);
        chk("R10", "pin0 oe forced", {7'd0, pin_oe[0]}, 8'h01);
        chk("R10", "pin0 pullup off", {7'd0, pin_pu[0]}, 8'h00);
        @(negedge clk); #1;
        chk("R10", "pin0 low phase", {7'd0, pin_out[0]}, 8'h01);
        wr(8'hE2, 8'h40);
        rd(8'hE2); chk("R10", "pin0 back to latch", {7'd0, pin_oe[0]}, 8'h01);
        chk("R10", "pin0 latch value", {7'd0, pin_out[0]}, 8'h00);

        // Mixed traffic checked by the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            case ($urandom_range(0, 3))
                0: bus_addr = 8'hE2;
                1: bus_addr = 8'h80;
                2: bus_addr = 8'hA4;
                default: bus_addr = 8'($urandom);
            endcase
            bus_wdata = 8'($urandom);
            bus_we = ($urandom_range(0, 2) == 0);
            pin_in = 8'($urandom);
        end

        // R11: reset during operation
        wr(8'hE2, 8'h81);
        wr(8'hA4, 8'h0F);
        @(negedge clk);
        bus_we = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'hE2); chk("R11", "ctrl after mid reset", bus_rdata, 8'h40);
        rd(8'hA4); chk("R11", "mode after mid reset", bus_rdata, 8'h00);
        chk("R11", "oe after mid reset", pin_oe, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule